// File: doc/BRIEF.md
# Event Timer Register Interface

This block is the memory-mapped register front end of a multi-timer event counter. A host reads and writes it over a simple request bus. Each request carries an address, a byte count, write data and a write flag. The block holds the following state:

- a general configuration word;
- an interrupt status word;
- a 32-bit main counter;
- for each of eight timers, a configuration word, a comparator and a message-route word.

It also produces a read-only capabilities word on demand. The comparator engines and the interrupt delivery logic sit outside this block. They consume the register contents through dedicated outputs, and they report timer events back through one set-pulse per timer.

Every register is 64 bits wide as the bus sees it. A bus access is either 8 bytes wide or a 4-byte half. A lane mask merges each write into the register, so a 4-byte write never disturbs the other half. An access with the wrong size or wrong alignment is dropped silently, and so is an access to an unused offset. The bus still receives a response one cycle later, so it never waits forever. The capabilities word and the current counter value are computed on each read rather than stored.

Top module: `evtmr_regif`

## Requirements
- R1: Only a byte count of exactly 4 or 8 is legal. A write with any other size changes no register, and a read with any other size returns all zeros.
- R2: An 8-byte access needs address bits 2:0 at zero, and a 4-byte access needs address bits 1:0 at zero. A misaligned write is dropped, and a misaligned read returns zero.
- R3: A 4-byte access with address bit 2 set targets register bits 63:32, and one with bit 2 clear targets bits 31:0. A 4-byte read returns the selected half in bits 31:0, with bits 63:32 of the response zero.
- R4: A legal write changes only the bits in its lane mask; every other bit of the register keeps its value.
- R5: The word at offset 0x000 is read-only, and writes to it are ignored. Its fields are:
  - bits 7:0 hold 1;
  - bits 12:8 hold the timer count minus one;
  - bits 15:13 are zero, and bit 13 at zero marks a 32-bit counter;
  - bits 31:16 hold a 16-bit vendor code (default 0xC0DE);
  - bits 63:32 hold the tick period in femtoseconds, which is 10^15 / 2^24 truncated (59604644).
- R6: The general configuration word sits at offset 0x010 and stores what is written, with two exceptions. Bit 1 always reads zero. Bit 0 is the counter run bit and drives `ctr_run`.
- R7: The interrupt status word sits at offset 0x020, with bit n belonging to timer n. A pulse on `irq_set[n]` sets bit n. Writing 1 to bit n clears it, and writing 0 leaves it unchanged. If a set and a clear of the same bit arrive in the same cycle, the set wins.
- R8: The main counter sits at offset 0x0F0. A write is merged into the zero-extended current count and then truncated to 32 bits, so a write to the upper half has no effect. A counter write takes priority over an increment in the same cycle.
- R9: While the run bit is set, the counter advances by one on each cycle with `tick_en` high and wraps from 0xFFFFFFFF to 0. While the run bit is clear, the counter holds its value.
- R10: A read of an offset that decodes to no register returns zero, and a write to such an offset changes nothing.
- R11: A request is accepted when `req_valid` and `req_ready` are both high. `rsp_valid` is high on the cycle after each accepted request and low at all other times, and writes and dropped accesses also get a response. Write responses carry zero data.
- R12: Timer n owns three registers based at 0x100 + 0x20·n:
  - a 64-bit configuration word at +0x00, reset 0;
  - a comparator at +0x08, stored as 32 bits and read zero-extended, reset 0xFFFFFFFF;
  - a 64-bit route word at +0x10, reset 0.
  
  Offset +0x18 is unused. The stored values appear on `tmr_cfg`, `tmr_cmp` and `tmr_route`, with timer n in slice n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counter tick strobe |
| irq_set | input | 8 | Per-timer status set pulses from the delivery logic |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset |
| req_size | input | 4 | Byte count of the access |
| req_wdata | input | 64 | Write data, low bytes used for 4-byte access |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 64 | Read data |
| ctr_value | output | 32 | Current main count |
| ctr_run | output | 1 | Counter run bit |
| tmr_cfg | output | 512 | Timer configuration words, 64 bits each |
| tmr_cmp | output | 256 | Timer comparators, 32 bits each |
| tmr_route | output | 512 | Timer route words, 64 bits each |

## Verification
The assertions assume the following about the inputs:
- `irq_set` is low whenever the status-clear property is checked;
- a full-width counter write is not paired with a conflicting increment expectation;
- requests never need to be held across cycles, because the interface accepts one per cycle once it is ready.

The stimulus keeps to these assumptions. It pulses `irq_set` only between bus transfers, except in the one test that deliberately collides a set with a clear. It moves `tick_en` only at falling edges, so the number of increments is exact. The sweeps cover the following:
- every byte count from 0 to 15;
- every misaligned low-address pattern;
- every register of every timer;
- the unused offsets.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

    localparam int OFF_CAPS   = 'h000;
    localparam int OFF_GCFG   = 'h010;
    localparam int OFF_ISR    = 'h020;
    localparam int OFF_CTR    = 'h0F0;
    localparam int OFF_TMR    = 'h100;
    localparam int TMR_SHIFT  = 5;       // 32-byte stride per timer

    localparam int GCFG_RUN_BIT = 0;
    localparam int GCFG_LEG_BIT = 1;

    localparam logic [63:0] TICK_FS = 64'd1000000000000000 / (64'd1 << 24);

    typedef struct packed {
        logic        ok;       // legal size and alignment
        logic        upper;    // 4-byte access to bits 63:32
        logic        full;     // 8-byte access
        logic [63:0] mask;
        logic [63:0] data;
    } acc_t;

    function automatic logic [63:0] lane_merge(input logic [63:0] old_v,
                                               input logic [63:0] new_v,
                                               input logic [63:0] mask);
        return (old_v & ~mask) | (new_v & mask);
    endfunction

endpackage

// File: rtl/evtmr_access_dec.sv
module evtmr_access_dec
    import evtmr_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic [AW-1:0] addr,
    input  logic [3:0]    size,
    input  logic [63:0]   wdata,
    output acc_t          acc
);
    logic size4, size8, aligned;

    always_comb begin
        size4   = (size == 4'd4);
        size8   = (size == 4'd8);
        aligned = size8 ? (addr[2:0] == 3'b000) : (addr[1:0] == 2'b00);

        acc.ok    = (size4 || size8) && aligned;
        acc.full  = size8;
        acc.upper = size4 && addr[2];

        if (size8) begin
            acc.mask = '1;
            acc.data = wdata;
        end else if (acc.upper) begin
            acc.mask = {32'hFFFF_FFFF, 32'h0};
            acc.data = {wdata[31:0], 32'h0};
        end else begin
            acc.mask = {32'h0, 32'hFFFF_FFFF};
            acc.data = {32'h0, wdata[31:0]};
        end
    end

    always_comb begin
        if (acc.ok) begin
            assert (acc.full ? (acc.mask == '1) : ($countones(acc.mask) == 32))
                else $error("AST_LANE_MASK_WIDTH"); // R3
        end
    end

endmodule

// File: rtl/evtmr_main_ctr.sv
module evtmr_main_ctr #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          wr,
    input  logic [63:0]   wmask,
    input  logic [63:0]   wdata,
    output logic [CW-1:0] count
);
    localparam int PAD = 64 - CW;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_st_t;

    ctr_st_t q, d;
    logic [63:0] merged;

    always_comb begin
        d      = q;
        merged = evtmr_pkg::lane_merge({{PAD{1'b0}}, q.cnt}, wdata, wmask);
        if (wr)
            d.cnt = merged[CW-1:0];
        else if (run && tick)
            d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count = q.cnt;

    AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !(run && tick)) |=> $stable(count)) else $error("AST_CTR_HOLD"); // R9

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && run && tick) |=> (count == CW'($past(count) + 1'b1))) else $error("AST_CTR_STEP"); // R9

    AST_CTR_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (wmask[CW-1:0] == '1)) |=> (count == $past(wdata[CW-1:0]))) else $error("AST_CTR_WR_WINS"); // R8

endmodule

// File: rtl/evtmr_timer_bank.sv
module evtmr_timer_bank
    import evtmr_pkg::*;
#(
    parameter int AW     = 10,
    parameter int NT     = 8,
    parameter int CMP_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [AW-4:0]     waddr,     // byte address bits AW-1:3
    input  logic [63:0]       mask,
    input  logic [63:0]       data,
    output logic              rd_hit,
    output logic [63:0]       rd_data,
    output logic [NT*64-1:0]  cfg_o,
    output logic [NT*CMP_W-1:0] cmp_o,
    output logic [NT*64-1:0]  route_o
);
    localparam int BLK_W    = AW - TMR_SHIFT;
    localparam int BASE_BLK = OFF_TMR >> TMR_SHIFT;
    localparam int PAD      = 64 - CMP_W;

    typedef struct packed {
        logic [NT-1:0][63:0]    cfg;
        logic [NT-1:0][CMP_W-1:0] cmp;
        logic [NT-1:0][63:0]    route;
    } bank_st_t;

    bank_st_t q, d;
    logic [NT-1:0] hit;
    logic [1:0]    sub;
    logic [63:0]   cmp_m;

    assign sub = waddr[1:0];

    for (genvar n = 0; n < NT; n++) begin : g_tmr
        assign hit[n] = (waddr[AW-4:2] == BLK_W'(BASE_BLK + n));
        assign cfg_o  [n*64    +: 64]    = q.cfg[n];
        assign cmp_o  [n*CMP_W +: CMP_W] = q.cmp[n];
        assign route_o[n*64    +: 64]    = q.route[n];
    end

    always_comb begin
        d       = q;
        rd_hit  = 1'b0;
        rd_data = '0;
        cmp_m   = '0;
        for (int n = 0; n < NT; n++) begin
            if (hit[n]) begin
                case (sub)
                    2'd0: begin
                        rd_hit  = 1'b1;
                        rd_data = q.cfg[n];
                        if (wr) d.cfg[n] = lane_merge(q.cfg[n], data, mask);
                    end
                    2'd1: begin
                        rd_hit  = 1'b1;
                        rd_data = {{PAD{1'b0}}, q.cmp[n]};
                        cmp_m   = lane_merge({{PAD{1'b0}}, q.cmp[n]}, data, mask);
                        if (wr) d.cmp[n] = cmp_m[CMP_W-1:0];
                    end
                    2'd2: begin
                        rd_hit  = 1'b1;
                        rd_data = q.route[n];
                        if (wr) d.route[n] = lane_merge(q.route[n], data, mask);
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cfg   <= '0;
            q.cmp   <= '1;
            q.route <= '0;
        end else begin
            q <= d;
        end
    end

    AST_TMR_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit)) else $error("AST_TMR_ONE_HIT"); // R12

    AST_TMR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(cfg_o) && $stable(cmp_o) && $stable(route_o))) else $error("AST_TMR_IDLE"); // R12

endmodule

// File: rtl/evtmr_regif.sv
module evtmr_regif
    import evtmr_pkg::*;
#(
    parameter int          AW        = 10,
    parameter int          NUM_TMR   = 8,
    parameter int          CTR_W     = 32,
    parameter logic [15:0] VENDOR_ID = 16'hC0DE
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_en,
    input  logic [NUM_TMR-1:0]      irq_set,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [AW-1:0]           req_addr,
    input  logic [3:0]              req_size,
    input  logic [63:0]             req_wdata,
    output logic                    rsp_valid,
    output logic [63:0]             rsp_rdata,
    output logic [CTR_W-1:0]        ctr_value,
    output logic                    ctr_run,
    output logic [NUM_TMR*64-1:0]   tmr_cfg,
    output logic [NUM_TMR*32-1:0]   tmr_cmp,
    output logic [NUM_TMR*64-1:0]   tmr_route
);
    localparam logic [AW-1:0] A_CAPS = AW'(OFF_CAPS);
    localparam logic [AW-1:0] A_GCFG = AW'(OFF_GCFG);
    localparam logic [AW-1:0] A_ISR  = AW'(OFF_ISR);
    localparam logic [AW-1:0] A_CTR  = AW'(OFF_CTR);
    localparam int            ISR_PAD = 64 - NUM_TMR;
    localparam int            CTR_PAD = 64 - CTR_W;

    typedef struct packed {
        logic               ready;
        logic [63:0]        gcfg;
        logic [NUM_TMR-1:0] isr;
        logic               rsp_valid;
        logic [63:0]        rdata;
    } top_st_t;

    top_st_t q, d;
    acc_t    dec;

    logic               accept, wr_ok, rd_ok;
    logic               hit_caps, hit_gcfg, hit_isr, hit_ctr;
    logic               bank_hit;
    logic [63:0]        bank_rd, raw_rd, shaped_rd, caps_word;
    logic [NUM_TMR-1:0] isr_clr;
    logic               wr_isr;

    evtmr_access_dec #(.AW(AW)) u_dec (
        .addr  (req_addr),
        .size  (req_size),
        .wdata (req_wdata),
        .acc   (dec)
    );

    evtmr_main_ctr #(.CW(CTR_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.gcfg[GCFG_RUN_BIT]),
        .tick  (tick_en),
        .wr    (wr_ok && hit_ctr),
        .wmask (dec.mask),
        .wdata (dec.data),
        .count (ctr_value)
    );

    evtmr_timer_bank #(.AW(AW), .NT(NUM_TMR), .CMP_W(32)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_ok),
        .waddr   (req_addr[AW-1:3]),
        .mask    (dec.mask),
        .data    (dec.data),
        .rd_hit  (bank_hit),
        .rd_data (bank_rd),
        .cfg_o   (tmr_cfg),
        .cmp_o   (tmr_cmp),
        .route_o (tmr_route)
    );

    assign caps_word = {TICK_FS[31:0], VENDOR_ID, 3'b000, 5'(NUM_TMR - 1), 8'h01};

    always_comb begin
        d = q;
        d.ready = 1'b1;

        accept = req_valid && q.ready;
        wr_ok  = accept && req_write && dec.ok;
        rd_ok  = accept && !req_write && dec.ok;

        hit_caps = (req_addr[AW-1:3] == A_CAPS[AW-1:3]);
        hit_gcfg = (req_addr[AW-1:3] == A_GCFG[AW-1:3]);
        hit_isr  = (req_addr[AW-1:3] == A_ISR[AW-1:3]);
        hit_ctr  = (req_addr[AW-1:3] == A_CTR[AW-1:3]);

        // general configuration: merge, legacy routing bit forced low
        if (wr_ok && hit_gcfg) begin
            d.gcfg = lane_merge(q.gcfg, dec.data, dec.mask);
            d.gcfg[GCFG_LEG_BIT] = 1'b0;
        end

        // status: write-one-to-clear, event sets take precedence
        wr_isr  = wr_ok && hit_isr;
        isr_clr = wr_isr ? (dec.data[NUM_TMR-1:0] & dec.mask[NUM_TMR-1:0]) : '0;
        d.isr   = (q.isr & ~isr_clr) | irq_set;

        // read path
        if (hit_caps)      raw_rd = caps_word;
        else if (hit_gcfg) raw_rd = q.gcfg;
        else if (hit_isr)  raw_rd = {{ISR_PAD{1'b0}}, q.isr};
        else if (hit_ctr)  raw_rd = {{CTR_PAD{1'b0}}, ctr_value};
        else if (bank_hit) raw_rd = bank_rd;
        else               raw_rd = '0;

        if (dec.full)       shaped_rd = raw_rd;
        else if (dec.upper) shaped_rd = {32'h0, raw_rd[63:32]};
        else                shaped_rd = {32'h0, raw_rd[31:0]};

        d.rsp_valid = accept;
        d.rdata     = rd_ok ? shaped_rd : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = q.ready;
    assign rsp_valid = q.rsp_valid;
    assign rsp_rdata = q.rdata;
    assign ctr_run   = q.gcfg[GCFG_RUN_BIT];

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid) else $error("AST_RSP_NEXT"); // R11

    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid) else $error("AST_RSP_IDLE"); // R11

    AST_BAD_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && !dec.ok) |=> (rsp_rdata == 64'd0)) else $error("AST_BAD_RD_ZERO"); // R1

    AST_BAD_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && !dec.ok) |=> ($stable(ctr_run) && $stable(tmr_cfg) && $stable(tmr_route))) else $error("AST_BAD_WR_DROP"); // R2

    AST_LEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && hit_gcfg) |=> (q.gcfg[GCFG_LEG_BIT] == 1'b0)) else $error("AST_LEG_ZERO"); // R6

    AST_ISR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_isr && (irq_set == '0)) |=> ((q.isr & $past(isr_clr)) == '0)) else $error("AST_ISR_CLR"); // R7

    AST_ISR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set != '0) |=> ((q.isr & $past(irq_set)) == $past(irq_set))) else $error("AST_ISR_SET"); // R7

endmodule

// File: tb/tb_evtmr_regif.sv
module tb_evtmr_regif;
    localparam int NT = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic [NT-1:0] irq_set = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [9:0]    req_addr = '0;
    logic [3:0]    req_size = '0;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_rdata;
    logic [31:0]   ctr_value;
    logic          ctr_run;
    logic [NT*64-1:0] tmr_cfg;
    logic [NT*32-1:0] tmr_cmp;
    logic [NT*64-1:0] tmr_route;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    evtmr_regif dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .irq_set(irq_set),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ctr_value(ctr_value), .ctr_run(ctr_run),
        .tmr_cfg(tmr_cfg), .tmr_cmp(tmr_cmp), .tmr_route(tmr_route)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    logic        last_v;
    logic [63:0] last_d;

    task automatic xfer(input logic w, input logic [9:0] a, input logic [3:0] s, input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        last_v = rsp_valid;
        last_d = rsp_rdata;
    endtask

    task automatic wr(input logic [9:0] a, input logic [3:0] s, input logic [63:0] wd);
        xfer(1'b1, a, s, wd);
    endtask

    task automatic rd(input logic [9:0] a, input logic [3:0] s);
        xfer(1'b0, a, s, 64'd0);
    endtask

    task automatic ticks(input int k);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (k) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] caps_exp, pat, e;
        logic [9:0]  base;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // reset state
        chk("R12", {63'd0, rsp_valid}, 64'd0, "reset rsp_valid");
        chk("R9",  {32'd0, ctr_value}, 64'd0, "reset counter");
        chk("R6",  {63'd0, ctr_run}, 64'd0, "reset run bit");
        chk("R12", {32'd0, tmr_cmp[31:0]}, 64'h0000_0000_FFFF_FFFF, "reset comparator");
        chk("R11", {63'd0, req_ready}, 64'd1, "ready after reset");

        // capabilities word (R5)
        caps_exp = ((64'd1000000000000000 / (64'd1 << 24)) << 32) | (64'hC0DE << 16) | (64'(NT - 1) << 8) | 64'd1;
        rd(10'h000, 4'd8);
        chk("R11", {63'd0, last_v}, 64'd1, "read response valid");
        chk("R5", last_d, caps_exp, "caps 8-byte");
        rd(10'h004, 4'd4);
        chk("R3", last_d, caps_exp >> 32, "caps upper half");
        rd(10'h000, 4'd4);
        chk("R3", last_d, caps_exp & 64'hFFFF_FFFF, "caps lower half");
        wr(10'h000, 4'd8, '1);
        chk("R11", {63'd0, last_v}, 64'd1, "write response valid");
        chk("R11", last_d, 64'd0, "write response data");
        rd(10'h000, 4'd8);
        chk("R5", last_d, caps_exp, "caps after write");

        // general configuration (R6, R4, R3)
        wr(10'h010, 4'd8, '1);
        rd(10'h010, 4'd8);
        chk("R6", last_d, ~64'h2, "config legacy bit reads zero");
        chk("R6", {63'd0, ctr_run}, 64'd1, "run bit set");
        wr(10'h010, 4'd8, 64'd0);
        wr(10'h014, 4'd4, 64'hAAAA_5555);
        rd(10'h010, 4'd8);
        chk("R4", last_d, 64'hAAAA_5555_0000_0000, "upper-half config write");
        wr(10'h010, 4'd4, 64'h1234_5678_0000_0002);
        rd(10'h010, 4'd8);
        chk("R4", last_d, 64'hAAAA_5555_0000_0000, "lower-half write, legacy bit dropped");
        chk("R6", {63'd0, ctr_run}, 64'd0, "run bit clear");

        // illegal sizes (R1)
        for (int s = 0; s < 16; s++) begin
            if (s != 4 && s != 8) begin
                wr(10'h110, 4'(s), '1);
                rd(10'h000, 4'(s));
                chk("R1", last_d, 64'd0, $sformatf("size %0d read", s));
            end
        end
        rd(10'h110, 4'd8);
        chk("R1", last_d, 64'd0, "route untouched by bad sizes");

        // misalignment (R2)
        for (int off = 1; off < 8; off++) begin
            wr(10'(10'h110 + off), 4'd8, '1);
            rd(10'(10'h000 + off), 4'd8);
            chk("R2", last_d, 64'd0, $sformatf("8-byte misaligned +%0d", off));
            if (off % 4 != 0) begin
                wr(10'(10'h110 + off), 4'd4, '1);
                rd(10'(10'h000 + off), 4'd4);
                chk("R2", last_d, 64'd0, $sformatf("4-byte misaligned +%0d", off));
            end
        end
        rd(10'h110, 4'd8);
        chk("R2", last_d, 64'd0, "route untouched by misaligned writes");

        // timer bank sweep (R12, R4, R3, R10)
        for (int n = 0; n < NT; n++) begin
            base = 10'(10'h100 + 32 * n);
            pat  = {32'hC0FF_0000 | 32'(n), 32'h00A0_0000 + 32'(n)};
            wr(base, 4'd8, pat);
            rd(base, 4'd8);
            chk("R12", last_d, pat, $sformatf("t%0d cfg", n));
            chk("R12", tmr_cfg[n*64 +: 64], pat, $sformatf("t%0d cfg port", n));
            wr(10'(base + 8), 4'd8, {32'hDEAD_0000, 32'h1234_0000 + 32'(n)});
            wr(10'(base + 12), 4'd4, 64'hFFFF_FFFF);
            rd(10'(base + 8), 4'd8);
            e = {32'd0, 32'h1234_0000 + 32'(n)};
            chk("R12", last_d, e, $sformatf("t%0d cmp zero-extended", n));
            chk("R12", {32'd0, tmr_cmp[n*32 +: 32]}, e, $sformatf("t%0d cmp port", n));
            wr(10'(base + 16), 4'd4, 64'h1111_0000 + 64'(n));
            wr(10'(base + 20), 4'd4, 64'h2222_0000 + 64'(n));
            e = {32'h2222_0000 + 32'(n), 32'h1111_0000 + 32'(n)};
            rd(10'(base + 16), 4'd8);
            chk("R4", last_d, e, $sformatf("t%0d route halves", n));
            chk("R12", tmr_route[n*64 +: 64], e, $sformatf("t%0d route port", n));
            rd(10'(base + 20), 4'd4);
            chk("R3", last_d, e >> 32, $sformatf("t%0d route upper read", n));
            wr(10'(base + 24), 4'd8, '1);
            rd(10'(base + 24), 4'd8);
            chk("R10", last_d, 64'd0, $sformatf("t%0d unused slot", n));
        end

        // unmapped offsets (R10)
        wr(10'h008, 4'd8, '1);
        wr(10'h030, 4'd8, '1);
        wr(10'h200, 4'd8, '1);
        wr(10'h3F8, 4'd8, '1);
        rd(10'h008, 4'd8); chk("R10", last_d, 64'd0, "read 0x008");
        rd(10'h030, 4'd8); chk("R10", last_d, 64'd0, "read 0x030");
        rd(10'h200, 4'd8); chk("R10", last_d, 64'd0, "read 0x200");
        rd(10'h3F8, 4'd8); chk("R10", last_d, 64'd0, "read 0x3F8");
        rd(10'h010, 4'd8); chk("R10", last_d, 64'hAAAA_5555_0000_0000, "config unchanged by unmapped writes");
        rd(10'h020, 4'd8); chk("R10", last_d, 64'd0, "status unchanged by unmapped writes");

        // interrupt status (R7)
        @(negedge clk); irq_set = 8'h5A;
        @(negedge clk); irq_set = 8'h00;
        rd(10'h020, 4'd8);
        chk("R7", last_d, 64'h5A, "status set by events");
        wr(10'h020, 4'd4, 64'h0F);
        rd(10'h020, 4'd8);
        chk("R7", last_d, 64'h50, "write-one-to-clear");
        wr(10'h024, 4'd4, 64'hFF);
        rd(10'h020, 4'd8);
        chk("R7", last_d, 64'h50, "upper-half write leaves status");
        irq_set = 8'h40;
        wr(10'h020, 4'd8, 64'h40);
        irq_set = 8'h00;
        rd(10'h020, 4'd8);
        chk("R7", last_d, 64'h50, "set wins over clear");
        wr(10'h020, 4'd8, 64'hFF);
        rd(10'h020, 4'd8);
        chk("R7", last_d, 64'd0, "all cleared");

        // main counter (R8, R9)
        wr(10'h010, 4'd8, 64'd0);
        wr(10'h0F0, 4'd8, 64'h1_FFFF_FFFE);
        rd(10'h0F0, 4'd8);
        chk("R8", last_d, 64'hFFFF_FFFE, "counter write truncated");
        wr(10'h0F4, 4'd4, 64'h55);
        rd(10'h0F0, 4'd8);
        chk("R8", last_d, 64'hFFFF_FFFE, "upper-half counter write ignored");
        ticks(5);
        chk("R9", {32'd0, ctr_value}, 64'hFFFF_FFFE, "hold while stopped");
        wr(10'h010, 4'd8, 64'd1);
        ticks(3);
        rd(10'h0F0, 4'd8);
        chk("R9", last_d, 64'd1, "count and wrap");
        rd(10'h0F4, 4'd4);
        chk("R3", last_d, 64'd0, "counter upper half reads zero");
        tick_en = 1'b1;
        wr(10'h0F0, 4'd4, 64'h100);
        tick_en = 1'b0;
        chk("R8", {32'd0, ctr_value}, 64'h100, "write beats increment");
        ticks(7);
        chk("R9", {32'd0, ctr_value}, 64'h107, "seven ticks");
        wr(10'h010, 4'd8, 64'd0);
        ticks(4);
        chk("R9", {32'd0, ctr_value}, 64'h107, "stopped again");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule